// File: doc/BRIEF.md
# ATM Cell Generator with Idle Insertion

This block produces the outgoing cell stream of one ATM transmit port. It runs a fixed 53-octet slot, one octet per clock, and at each slot boundary decides what goes out. If the port is served, it streams the port's cell through from an octet input. If another port takes the slot, it stays silent. If nobody transmits, it builds an idle cell from a programmed 4-octet header and a programmed fill octet. In every cell it can overwrite the header check octet with a computed CRC-8 value. It can also overwrite the low ten bits of the payload tail with a computed CRC-10 value.

Software controls the block through two disable levels, an error pattern and three one-shot request pulses. The three requests are HEC corruption, payload CRC corruption, and replacement of the port's next served cell with an idle cell. Each request has a pending flag that software can poll. A pending flag clears by itself once the request has been carried out. All cell controls are sampled only at the slot boundary, so a cell is never built from a mix of settings.

Top module: `atm_cellgen`

## Requirements
- R1: Slots are 53 octets long and follow each other without gaps from reset. Octet k of a slot is presented at the output one clock after the clock in which the block takes it. `out_sop` marks octet 0 of every emitted cell.
- R2: The slot type is decided at octet 0. With `port_sel` high the cell is a data cell: `in_rd` is high for all 53 octets and the octets of `in_octet` are passed through. With only `other_sel` high, `out_valid` stays low for the whole slot. With neither high, an idle cell is sent and `out_idle` is high for all of its octets.
- R3: An idle cell carries `idle_hdr[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` as octets 0 to 3. Payload octets 5 to 52 carry `idle_fill`, except where R5 overwrites them.
- R4: When HEC generation is enabled, octet 4 equals 0x55 XOR the CRC-8 of octets 0 to 3. The CRC-8 uses generator x^8+x^2+x+1 and a zero start value, and takes each octet MSB first.
- R5: When payload CRC generation is enabled, the CRC-10 is computed over the payload bits that precede the last ten bits. It uses generator x^10+x^9+x^5+x^4+x+1, a zero start value, and MSB first order. Its bits [9:8] go into bits [1:0] of octet 51 and its bits [7:0] into octet 52. Bits [7:2] of octet 51 pass unchanged.
- R6: `dis_hec` high makes octet 4 pass from the source: the data input, or 0x00 in an idle cell. `dis_crc` high makes octets 51 and 52 pass from the source.
- R7: A `set_err_hec` pulse sets `pend_err_hec`. The next emitted cell takes the flag, clears it at its octet 0, and has its generated HEC XORed with `err_pat`. A zero pattern or a disabled HEC leaves octet 4 as R4 or R6 gives it.
- R8: A `set_err_crc` pulse sets `pend_err_crc`. The next emitted cell takes and clears the flag, and with CRC generation enabled the low 4 bits of octet 52 are inverted.
- R9: A `set_inhibit` pulse sets `pend_inhibit`. At the next slot with `port_sel` high, an idle cell with the idle header and an all-zero payload is sent instead, and `in_rd` stays low. The flag stays set until the last octet of that cell has been taken.
- R10: A pending inhibit is cleared at a slot boundary where only `other_sel` is high. It remains pending through ordinary idle slots.
- R11: Changes to `dis_hec`, `dis_crc` and `err_pat` during a slot do not affect the cell in progress.
- R12: During reset `out_valid`, `out_sop`, `out_idle` and all three pending flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | This port is served in the slot starting now |
| other_sel | input | 1 | Another port is served in the slot starting now |
| in_octet | input | 8 | Data cell octet for the current slot position |
| in_rd | output | 1 | The block consumes `in_octet` this clock |
| idle_hdr | input | 32 | Idle cell header, octet 0 in the top byte |
| idle_fill | input | 8 | Idle cell payload fill octet |
| dis_hec | input | 1 | Pass octet 4 instead of generating it |
| dis_crc | input | 1 | Pass the CRC-10 field instead of generating it |
| err_pat | input | 8 | Pattern XORed into a corrupted HEC |
| set_err_hec | input | 1 | Request one HEC error |
| set_err_crc | input | 1 | Request one payload CRC error |
| set_inhibit | input | 1 | Request one idle cell in place of a data cell |
| pend_err_hec | output | 1 | HEC error request pending |
| pend_err_crc | output | 1 | CRC error request pending |
| pend_inhibit | output | 1 | Inhibit request pending |
| out_valid | output | 1 | Output octet valid |
| out_sop | output | 1 | Output octet is octet 0 of a cell |
| out_idle | output | 1 | Output octet belongs to an idle cell |
| out_octet | output | 8 | Output cell octet |

## Verification
The hardest case to reach is the life of a pending inhibit, because its outcome depends on which kind of slot comes next. The stimulus pulses the request in the middle of one cell. It then runs an ordinary idle slot, which must leave the request pending. After that comes either a served slot, which must produce a zero-payload idle cell and clear the flag only at its end, or a lost slot, which must clear the flag at once. Error requests are armed the same way in the middle of a cell and checked on the following cell, including with generation disabled and with a zero pattern. A mid-cell toggle of the disable level shows that the cell keeps the setting taken at its boundary.

// File: rtl/atm_cellgen_pkg.sv
package atm_cellgen_pkg;

  typedef enum logic [1:0] {K_NONE, K_DATA, K_IDLE, K_INH} cell_kind_e;

  typedef struct packed {
    cell_kind_e  kind;
    logic        dis_hec;
    logic        dis_crc;
    logic        err_hec;
    logic        err_crc;
    logic [7:0]  pat;
  } cell_ctx_t;

  // CRC-8, generator x^8+x^2+x+1, one octet MSB first
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  // CRC-10, generator x^10+x^9+x^5+x^4+x+1, top n bits of d MSB first
  function automatic logic [9:0] crc10_bits(input logic [9:0] crc, input logic [7:0] d, input int n);
    logic [9:0] c;
    logic       fb;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        fb = c[9] ^ d[7-i];
        c  = {c[8:0], 1'b0} ^ (fb ? 10'h233 : 10'h000);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/atm_cellgen_seq.sv
module atm_cellgen_seq
  import atm_cellgen_pkg::*;
#(
  parameter int CELL_OCTETS = 53,
  localparam int IDX_W = $clog2(CELL_OCTETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_sel,
  input  logic             other_sel,
  input  logic             set_err_hec,
  input  logic             set_err_crc,
  input  logic             set_inhibit,
  input  logic             dis_hec,
  input  logic             dis_crc,
  input  logic [7:0]       err_pat,
  output logic [IDX_W-1:0] idx,
  output cell_ctx_t        ctx_now,
  output logic             pend_err_hec,
  output logic             pend_err_crc,
  output logic             pend_inhibit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_OCTETS - 1);

  logic [IDX_W-1:0] idx_q;
  cell_ctx_t        ctx_q, fresh;

  // named events for the assertions
  wire at_sop     = (idx_q == '0);
  wire at_last    = (idx_q == LAST);
  wire slot_lost  = at_sop && (fresh.kind == K_NONE);
  wire cell_start = at_sop && (fresh.kind != K_NONE);
  wire inh_done   = at_last && (ctx_q.kind == K_INH);

  always_comb begin
    fresh.kind    = K_IDLE;
    fresh.dis_hec = dis_hec;
    fresh.dis_crc = dis_crc;
    fresh.err_hec = pend_err_hec;
    fresh.err_crc = pend_err_crc;
    fresh.pat     = err_pat;
    if (port_sel)       fresh.kind = pend_inhibit ? K_INH : K_DATA;
    else if (other_sel) fresh.kind = K_NONE;
  end

  assign ctx_now = at_sop ? fresh : ctx_q;
  assign idx     = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      ctx_q        <= '0;
      pend_err_hec <= 1'b0;
      pend_err_crc <= 1'b0;
      pend_inhibit <= 1'b0;
    end else begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
      ctx_q <= ctx_now;
      if (set_err_hec)     pend_err_hec <= 1'b1;
      else if (cell_start) pend_err_hec <= 1'b0;
      if (set_err_crc)     pend_err_crc <= 1'b1;
      else if (cell_start) pend_err_crc <= 1'b0;
      if (set_inhibit)                 pend_inhibit <= 1'b1;
      else if (slot_lost || inh_done)  pend_inhibit <= 1'b0;
    end
  end

  a_r1_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (idx_q == '0));
  a_r7_hec_req_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && !set_err_hec) |=> !pend_err_hec);
  a_r8_crc_req_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && !set_err_crc) |=> !pend_err_crc);
  a_r9_inh_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_done && !set_inhibit) |=> !pend_inhibit);
  a_r10_lost_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sop && other_sel && !port_sel && !set_inhibit) |=> !pend_inhibit);

endmodule

// File: rtl/atm_cellgen_dp.sv
module atm_cellgen_dp
  import atm_cellgen_pkg::*;
#(
  parameter int CELL_OCTETS = 53,
  parameter int HDR_OCTETS  = 4,
  localparam int IDX_W = $clog2(CELL_OCTETS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx,
  input  cell_ctx_t               ctx,
  input  logic [7:0]              in_octet,
  input  logic [8*HDR_OCTETS-1:0] idle_hdr,
  input  logic [7:0]              idle_fill,
  output logic                    out_valid,
  output logic                    out_sop,
  output logic                    out_idle,
  output logic [7:0]              out_octet
);
  localparam logic [IDX_W-1:0] HEC_IDX   = IDX_W'(HDR_OCTETS);
  localparam logic [IDX_W-1:0] PAY_FIRST = IDX_W'(HDR_OCTETS + 1);
  localparam logic [IDX_W-1:0] CRC_HI    = IDX_W'(CELL_OCTETS - 2);
  localparam logic [IDX_W-1:0] LAST      = IDX_W'(CELL_OCTETS - 1);

  logic [7:0] raw, hdr_byte, octet_nx;
  logic [7:0] crc8_q, crc8_nx;
  logic [9:0] crc10_q, crc10_base, crc10_full, crc10_part, crc10_fin_q;
  logic [7:0] hec_gen;
  logic       emit, is_idle;

  assign emit    = (ctx.kind != K_NONE);
  assign is_idle = (ctx.kind == K_IDLE) || (ctx.kind == K_INH);

  always_comb begin
    hdr_byte = 8'h00;
    for (int i = 0; i < HDR_OCTETS; i++)
      if (idx == IDX_W'(i)) hdr_byte = idle_hdr[8*(HDR_OCTETS-1-i) +: 8];
  end

  always_comb begin
    if (ctx.kind == K_DATA)     raw = in_octet;
    else if (idx < HEC_IDX)     raw = hdr_byte;
    else if (idx == HEC_IDX)    raw = 8'h00;
    else if (ctx.kind == K_INH) raw = 8'h00;
    else                        raw = idle_fill;
  end

  assign crc8_nx    = crc8_byte((idx == '0) ? 8'h00 : crc8_q, raw);
  assign hec_gen    = crc8_q ^ 8'h55 ^ (ctx.err_hec ? ctx.pat : 8'h00);
  assign crc10_base = (idx == PAY_FIRST) ? 10'h000 : crc10_q;
  assign crc10_full = crc10_bits(crc10_base, raw, 8);
  assign crc10_part = crc10_bits(crc10_base, raw, 6);

  always_comb begin
    octet_nx = raw;
    if (idx == HEC_IDX && !ctx.dis_hec) octet_nx = hec_gen;
    if (idx == CRC_HI && !ctx.dis_crc)  octet_nx = {raw[7:2], crc10_part[9:8]};
    if (idx == LAST && !ctx.dis_crc)
      octet_nx = crc10_fin_q[7:0] ^ (ctx.err_crc ? 8'h0F : 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc8_q      <= '0;
      crc10_q     <= '0;
      crc10_fin_q <= '0;
      out_valid   <= 1'b0;
      out_sop     <= 1'b0;
      out_idle    <= 1'b0;
      out_octet   <= '0;
    end else begin
      if (idx < HEC_IDX) crc8_q <= crc8_nx;
      if (idx >= PAY_FIRST && idx < CRC_HI) crc10_q <= crc10_full;
      if (idx == CRC_HI) crc10_fin_q <= crc10_part;
      out_valid <= emit;
      out_sop   <= emit && (idx == '0);
      out_idle  <= emit && is_idle;
      out_octet <= emit ? octet_nx : 8'h00;
    end
  end

  a_r1_valid_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0) |=> (out_valid == $past(out_valid)));

endmodule

// File: rtl/atm_cellgen.sv
module atm_cellgen
  import atm_cellgen_pkg::*;
#(
  parameter int CELL_OCTETS = 53,
  parameter int HDR_OCTETS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_sel,
  input  logic        other_sel,
  input  logic [7:0]  in_octet,
  output logic        in_rd,
  input  logic [31:0] idle_hdr,
  input  logic [7:0]  idle_fill,
  input  logic        dis_hec,
  input  logic        dis_crc,
  input  logic [7:0]  err_pat,
  input  logic        set_err_hec,
  input  logic        set_err_crc,
  input  logic        set_inhibit,
  output logic        pend_err_hec,
  output logic        pend_err_crc,
  output logic        pend_inhibit,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_idle,
  output logic [7:0]  out_octet
);
  localparam int IDX_W = $clog2(CELL_OCTETS);

  logic [IDX_W-1:0] idx;
  cell_ctx_t        ctx_now;

  atm_cellgen_seq #(.CELL_OCTETS(CELL_OCTETS)) u_seq (
    .clk, .rst_n, .port_sel, .other_sel, .set_err_hec, .set_err_crc, .set_inhibit,
    .dis_hec, .dis_crc, .err_pat, .idx, .ctx_now,
    .pend_err_hec, .pend_err_crc, .pend_inhibit
  );

  atm_cellgen_dp #(.CELL_OCTETS(CELL_OCTETS), .HDR_OCTETS(HDR_OCTETS)) u_dp (
    .clk, .rst_n, .idx, .ctx(ctx_now), .in_octet,
    .idle_hdr(idle_hdr[8*HDR_OCTETS-1:0]), .idle_fill,
    .out_valid, .out_sop, .out_idle, .out_octet
  );

  assign in_rd = (ctx_now.kind == K_DATA);

  wire at_sop = (idx == '0);

  a_r1_sop_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |=> !out_sop);
  a_r2_lost_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sop && other_sel && !port_sel) |=> !out_valid);
  a_r9_inh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sop && port_sel && pend_inhibit) |=> (out_sop && out_idle && !in_rd));

endmodule

// File: tb/sim_atm_cellgen.sv
`timescale 1ns/1ps
module sim_atm_cellgen;
  localparam int MD_DATA = 0, MD_OTHER = 1, MD_IDLE = 2;
  localparam int KD_NONE = 0, KD_DATA = 1, KD_IDLE = 2, KD_INH = 3;

  logic clk = 0, rst_n = 0;
  logic port_sel = 0, other_sel = 0, in_rd;
  logic [7:0] in_octet = 0, idle_fill = 8'h6A, err_pat = 8'h81, out_octet;
  logic [31:0] idle_hdr = 32'h0000_0001;
  logic dis_hec = 0, dis_crc = 0, set_err_hec = 0, set_err_crc = 0, set_inhibit = 0;
  logic pend_err_hec, pend_err_crc, pend_inhibit, out_valid, out_sop, out_idle;

  int checks = 0, failures = 0;
  bit m_eh = 0, m_ec = 0, m_inh = 0;

  typedef struct { bit v; bit s; bit i; logic [7:0] o; int tag; int pos; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  atm_cellgen u0 (.*);

  // HEC by long division of header*x^8 (R4)
  function automatic logic [7:0] hec_ref(input logic [31:0] h);
    logic [39:0] m;
    m = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (m[i]) m[i -: 9] = m[i -: 9] ^ 9'h107;
    return m[7:0] ^ 8'h55;
  endfunction

  // CRC-10 by long division: payload with its last 10 bits zeroed (R5)
  function automatic logic [9:0] crc10_ref(input logic [383:0] p);
    logic [383:0] m;
    m = p;
    m[9:0] = '0;
    for (int i = 383; i >= 10; i--) if (m[i]) m[i -: 11] = m[i -: 11] ^ 11'h633;
    return m[9:0];
  endfunction

  task automatic chk(input bit ok, input int tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare each produced octet with the scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({out_valid, out_sop, out_idle} == {e.v, e.s, e.i}, e.tag, $sformatf("flags octet %0d", e.pos),
            {out_valid, out_sop, out_idle}, {e.v, e.s, e.i});
        if (e.v) chk(out_octet == e.o, e.tag, $sformatf("octet %0d", e.pos), out_octet, e.o);
      end
    end
  end

  task automatic send_cell(input int mode, input logic [31:0] hdr, input logic [7:0] seed,
                           input bit p_eh, input bit p_ec, input bit p_inh, input bit tog);
    logic [7:0] e [53];
    logic [383:0] pay;
    logic [9:0] c10;
    int kind;
    bit ceh, cec, cdh, cdc;
    logic [7:0] cpat;
    kind = (mode == MD_OTHER) ? KD_NONE : (mode == MD_IDLE) ? KD_IDLE : (m_inh ? KD_INH : KD_DATA);
    ceh = 0; cec = 0;
    if (kind == KD_NONE) m_inh = 0;     // R10
    else begin ceh = m_eh; cec = m_ec; m_eh = 0; m_ec = 0; end
    cdh = dis_hec; cdc = dis_crc; cpat = err_pat;   // sampled at boundary (R11)
    for (int i = 0; i < 53; i++) begin
      if (kind == KD_DATA) e[i] = (i < 4) ? hdr[8*(3-i) +: 8] : (i == 4) ? 8'hA5 : seed + 8'(i);
      else e[i] = (i < 4) ? idle_hdr[8*(3-i) +: 8] : (i == 4 || kind == KD_INH) ? 8'h00 : idle_fill;
    end
    if (!cdh) e[4] = hec_ref({e[0], e[1], e[2], e[3]}) ^ (ceh ? cpat : 8'h00);
    if (!cdc) begin
      for (int i = 0; i < 48; i++) pay[8*(47-i) +: 8] = e[5+i];
      c10 = crc10_ref(pay);
      e[51][1:0] = c10[9:8];
      e[52] = c10[7:0] ^ (cec ? 8'h0F : 8'h00);
    end
    for (int k = 0; k < 53; k++) begin
      exp_t it;
      @(negedge clk);
      rst_n = 1;
      port_sel  = (k == 0) && (mode == MD_DATA);
      other_sel = (k == 0) && (mode == MD_OTHER);
      in_octet  = (kind == KD_DATA) ? e[k] : 8'hEE;
      if (kind == KD_DATA && (k == 4 || ((k == 51 || k == 52) && !cdc))) in_octet = (k == 4) ? 8'hA5 : 8'h3C;
      if (kind == KD_DATA && k == 51 && !cdc) in_octet = {e[51][7:2], 2'b00};
      if (tog) dis_hec = (k == 0) ? cdh : ~cdh;                 // R11 mid-cell toggle
      set_err_hec = p_eh && k == 10; set_err_crc = p_ec && k == 10; set_inhibit = p_inh && k == 10;
      if (k == 10) begin m_eh |= p_eh; m_ec |= p_ec; m_inh |= p_inh; end
      it.v = (kind != KD_NONE); it.s = it.v && k == 0; it.i = (kind == KD_IDLE || kind == KD_INH);
      it.o = e[k]; it.pos = k;
      it.tag = (kind == KD_NONE) ? 2 : (k < 4) ? 3 : (k == 4) ? 4 : (k >= 51) ? 5 : 2;
      q.push_back(it);
      #1;
      if (k == 0 || k == 30)   // R2 consumption strobe
        chk(in_rd == (kind == KD_DATA), 2, "in_rd", in_rd, kind == KD_DATA);
      if (k == 1) begin        // R7 R8 R9 R10 pending flags
        chk(pend_err_hec == m_eh, 7, "pend_err_hec", pend_err_hec, m_eh);
        chk(pend_err_crc == m_ec, 8, "pend_err_crc", pend_err_crc, m_ec);
        chk(pend_inhibit == m_inh, 9, "pend_inhibit", pend_inhibit, m_inh);
      end
      if (k == 52 && kind == KD_INH) m_inh = 0;
    end
    if (tog) dis_hec = cdh;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL R1 watchdog expired: actual 1 expected 0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({out_valid, out_sop, out_idle} == 3'b000, 12, "out flags in reset", {out_valid, out_sop, out_idle}, 0);
    chk({pend_err_hec, pend_err_crc, pend_inhibit} == 3'b000, 12, "pending in reset",
        {pend_err_hec, pend_err_crc, pend_inhibit}, 0);
    send_cell(MD_DATA,  32'h0000_0000, 8'h00, 0, 0, 0, 0);  // R1 R4: HEC 0x55
    send_cell(MD_IDLE,  32'h0,         8'h00, 0, 0, 0, 0);  // R3 idle cell
    send_cell(MD_DATA,  32'h1234_5678, 8'h40, 0, 0, 0, 0);  // R5
    send_cell(MD_OTHER, 32'h0,         8'h00, 0, 0, 0, 0);  // R2 lost slot
    send_cell(MD_DATA,  32'hCAFE_0010, 8'h11, 1, 0, 0, 0);  // arm R7
    send_cell(MD_DATA,  32'hCAFE_0020, 8'h22, 0, 1, 0, 0);  // R7 applied, arm R8
    send_cell(MD_IDLE,  32'h0,         8'h00, 0, 0, 0, 0);  // R8 applied on idle
    dis_hec = 1; dis_crc = 1;
    send_cell(MD_DATA,  32'hABCD_EF01, 8'h33, 1, 1, 0, 0);  // R6 pass-through, arm
    send_cell(MD_IDLE,  32'h0,         8'h00, 0, 0, 0, 0);  // R6 idle, errors absorbed
    dis_hec = 0; dis_crc = 0;
    send_cell(MD_DATA,  32'h0102_0304, 8'h44, 0, 0, 0, 0);  // no leftover error
    err_pat = 8'h00;
    send_cell(MD_DATA,  32'h0A0B_0C0D, 8'h55, 1, 0, 0, 0);  // arm zero pattern
    send_cell(MD_DATA,  32'h0A0B_0C0E, 8'h66, 0, 0, 1, 0);  // R7 zero pattern, arm R9
    err_pat = 8'h3C;
    send_cell(MD_IDLE,  32'h0,         8'h00, 0, 0, 0, 0);  // R10 stays pending
    send_cell(MD_DATA,  32'h1111_2222, 8'h77, 0, 0, 0, 0);  // R9 zero-payload idle
    send_cell(MD_DATA,  32'h1111_2223, 8'h78, 0, 0, 1, 0);  // served again, arm inhibit
    send_cell(MD_OTHER, 32'h0,         8'h00, 0, 0, 0, 0);  // R10 cleared by lost slot
    send_cell(MD_DATA,  32'h5555_AAAA, 8'h88, 1, 0, 0, 1);  // R11 toggle
    send_cell(MD_DATA,  32'hFFFF_FFFF, 8'hF0, 0, 0, 0, 1);  // R11 toggle, R7 applied
    send_cell(MD_DATA,  32'h8000_0000, 8'h99, 0, 0, 0, 0);
    @(negedge clk); port_sel = 0; other_sel = 1;
    repeat (3) @(negedge clk);
    chk({pend_err_hec, pend_err_crc, pend_inhibit} == 3'b000, 9, "pending at end",
        {pend_err_hec, pend_err_crc, pend_inhibit}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule